// File: doc/BRIEF.md
# Commit Result Checker

This block sits at the end of an out-of-order pipeline, just before architectural commit. The core hands it retiring instructions in program order. Each one carries the core's claimed PC, instruction word, source operands, result and next PC. Alongside these, the block receives its own copy of the instruction word and operands, taken from its private fetch and register-file read ports. It recomputes the result and the next PC with a small integer ALU, compares every field against the core's claim, and commits its own values. When any field disagrees, it also orders a restart of the core at the corrected next PC.

A watchdog covers the case where the core stops retiring altogether. If no instruction is accepted within a parameterized number of cycles, the block asks for a restart at the PC it expects next. It then spends a fixed number of instructions in a recovery mode. In that mode every claim from the core is ignored and the PC advances only from the block's own next-PC computation.

The opcode occupies the top four bits of the instruction word. The recognised values are 0 add, 1 subtract, 2 and, 3 or, 4 xor and 5 branch. A branch computes its target as PC + operand B. That target is both its result and its next PC. Every other instruction has next PC = PC + 4.

Top module: `commit_chk`

## Requirements
- R1: After reset, `in_ready` is 1, `cmt_valid`, `rst_req`, `recov`, `err_sticky` are 0, `mis_cnt` is 0, and the first expected PC is `RESET_PC`.
- R2: An accepted instruction is committed in the next cycle with `cmt_pc` = the expected PC, `cmt_instr` = the checker's instruction word and `cmt_npc` = the checker's next PC. For opcodes 0..5, `cmt_res` = the recomputed result using the checker's operands: a+b, a-b, a&b, a|b, a^b, or PC+b for opcode 5. The expected PC of the next instruction is the committed `cmt_npc`.
- R3: `cmt_fix` reports which comparisons failed. Bit 0 is PC, bit 1 is instruction word, bit 2 is either operand, bit 3 is result and bit 4 is next PC. Bits 2 and 3 are only set for opcodes 0..5.
- R4: When `cmt_fix` is non-zero, `rst_req` is high in the same cycle as the commit, for exactly one cycle, with `rst_pc` = `cmt_npc`. When `cmt_fix` is zero, `rst_req` stays low.
- R5: `in_ready` is 0 in the cycle in which `rst_req` is high, and 1 again in the cycle after.
- R6: For opcodes outside 0..5, the core's result is committed unchanged, and a wrong result or operand raises no fix bit and no restart.
- R7: If `WD_LIMIT` consecutive clock edges pass without an accepted instruction, `rst_req` pulses after the last of them with `rst_pc` = the expected PC, and `recov` becomes 1.
- R8: An instruction accepted on the edge at which the watchdog would expire cancels the expiry: no restart, and counting starts again from zero.
- R9: While `recov` is 1, all core fields are ignored. `cmt_fix` is 0, no restart is issued and `mis_cnt` is unchanged. Pass-through opcodes commit a result of 0. `recov` returns to 0 after `RECOV_LEN` accepted instructions.
- R10: `mis_cnt` increments on every commit with a non-zero `cmt_fix` and saturates at its maximum. `err_sticky` is set by the first such commit and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Core offers a retiring instruction |
| in_ready | output | 1 | Checker can accept this cycle |
| core_pc | input | XLEN | Core's PC for the instruction |
| core_instr | input | XLEN | Core's instruction word |
| core_a | input | XLEN | Core's operand A |
| core_b | input | XLEN | Core's operand B |
| core_res | input | XLEN | Core's claimed result or address |
| core_npc | input | XLEN | Core's claimed next PC |
| ref_instr | input | XLEN | Instruction word from the checker's own fetch |
| ref_a | input | XLEN | Operand A from the checker's own register read |
| ref_b | input | XLEN | Operand B from the checker's own register read |
| cmt_valid | output | 1 | Commit strobe |
| cmt_pc | output | XLEN | Committed PC |
| cmt_instr | output | XLEN | Committed instruction word |
| cmt_res | output | XLEN | Committed result |
| cmt_npc | output | XLEN | Committed next PC |
| cmt_fix | output | 5 | Mask of failed comparisons |
| rst_req | output | 1 | One-cycle core restart request |
| rst_pc | output | XLEN | PC at which the core restarts |
| recov | output | 1 | Recovery mode active |
| mis_cnt | output | CNT_W | Saturating count of corrected commits |
| err_sticky | output | 1 | Set once any correction has occurred |

## Verification
The watchdog expiry and the acceptance of a late instruction can land on the same clock edge. The bench lets exactly `WD_LIMIT`-1 idle edges pass after a clean commit and then offers an instruction, so that it is accepted on the expiring edge. It then requires a clean commit, no restart pulse and recovery still off. A separate run leaves the line idle for one more edge and requires the restart and recovery to appear at exactly that cycle.

// File: rtl/commit_chk_pkg.sv
package commit_chk_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD = 4'd0,
        OPC_SUB = 4'd1,
        OPC_AND = 4'd2,
        OPC_OR  = 4'd3,
        OPC_XOR = 4'd4,
        OPC_BRA = 4'd5
    } opc_e;

    localparam int FIX_W   = 5;
    localparam int FIX_PC  = 0;
    localparam int FIX_INS = 1;
    localparam int FIX_OPD = 2;
    localparam int FIX_RES = 3;
    localparam int FIX_NPC = 4;

endpackage

// File: rtl/commit_chk_alu.sv
module commit_chk_alu
    import commit_chk_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PC_STEP = 4
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  res,
    output logic [XLEN-1:0]  npc,
    output logic             known
);
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        seq_pc = pc + XLEN'(PC_STEP);
        res    = '0;
        npc    = seq_pc;
        known  = 1'b1;
        case (opc)
            OPC_ADD: res = a + b;
            OPC_SUB: res = a - b;
            OPC_AND: res = a & b;
            OPC_OR:  res = a | b;
            OPC_XOR: res = a ^ b;
            OPC_BRA: begin
                res = pc + b;
                npc = pc + b;
            end
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/commit_chk_cmp.sv
module commit_chk_cmp
    import commit_chk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             enable,
    input  logic             known,
    input  logic [XLEN-1:0]  core_pc,
    input  logic [XLEN-1:0]  own_pc,
    input  logic [XLEN-1:0]  core_instr,
    input  logic [XLEN-1:0]  own_instr,
    input  logic [XLEN-1:0]  core_a,
    input  logic [XLEN-1:0]  own_a,
    input  logic [XLEN-1:0]  core_b,
    input  logic [XLEN-1:0]  own_b,
    input  logic [XLEN-1:0]  core_res,
    input  logic [XLEN-1:0]  own_res,
    input  logic [XLEN-1:0]  core_npc,
    input  logic [XLEN-1:0]  own_npc,
    output logic [FIX_W-1:0] fix
);
    logic [FIX_W-1:0] raw;

    always_comb begin
        raw          = '0;
        raw[FIX_PC]  = core_pc != own_pc;
        raw[FIX_INS] = core_instr != own_instr;
        raw[FIX_OPD] = known && ((core_a != own_a) || (core_b != own_b));
        raw[FIX_RES] = known && (core_res != own_res);
        raw[FIX_NPC] = core_npc != own_npc;
        fix          = enable ? raw : '0;
    end
endmodule

// File: rtl/commit_chk_wdog.sv
module commit_chk_wdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = !kick && (cnt_q == CW'(LIMIT - 1));
        if (kick || expire) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/commit_chk.sv
module commit_chk
    import commit_chk_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              PC_STEP   = 4,
    parameter int              WD_LIMIT  = 1024,
    parameter int              RECOV_LEN = 4,
    parameter int              CNT_W     = 8,
    parameter logic [XLEN-1:0] RESET_PC  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [XLEN-1:0]  core_pc,
    input  logic [XLEN-1:0]  core_instr,
    input  logic [XLEN-1:0]  core_a,
    input  logic [XLEN-1:0]  core_b,
    input  logic [XLEN-1:0]  core_res,
    input  logic [XLEN-1:0]  core_npc,
    input  logic [XLEN-1:0]  ref_instr,
    input  logic [XLEN-1:0]  ref_a,
    input  logic [XLEN-1:0]  ref_b,
    output logic             cmt_valid,
    output logic [XLEN-1:0]  cmt_pc,
    output logic [XLEN-1:0]  cmt_instr,
    output logic [XLEN-1:0]  cmt_res,
    output logic [XLEN-1:0]  cmt_npc,
    output logic [FIX_W-1:0] cmt_fix,
    output logic             rst_req,
    output logic [XLEN-1:0]  rst_pc,
    output logic             recov,
    output logic [CNT_W-1:0] mis_cnt,
    output logic             err_sticky
);
    localparam int RL_W = $clog2(RECOV_LEN + 1);

    typedef struct packed {
        logic             hold;
        logic [XLEN-1:0]  exp_pc;
        logic             cv;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  instr;
        logic [XLEN-1:0]  res;
        logic [XLEN-1:0]  npc;
        logic [FIX_W-1:0] fix;
        logic             rreq;
        logic [XLEN-1:0]  rpc;
        logic             recov;
        logic [RL_W-1:0]  left;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } st_t;

    st_t st_d, st_q;

    logic             accept;
    logic             expire;
    logic [XLEN-1:0]  own_res;
    logic [XLEN-1:0]  own_npc;
    logic             known;
    logic [FIX_W-1:0] fix;

    assign accept = in_valid && !st_q.hold;

    commit_chk_alu #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_alu (
        .opc   (ref_instr[XLEN-1 -: OPC_W]),
        .pc    (st_q.exp_pc),
        .a     (ref_a),
        .b     (ref_b),
        .res   (own_res),
        .npc   (own_npc),
        .known (known)
    );

    commit_chk_cmp #(.XLEN(XLEN)) u_cmp (
        .enable     (!st_q.recov),
        .known      (known),
        .core_pc    (core_pc),
        .own_pc     (st_q.exp_pc),
        .core_instr (core_instr),
        .own_instr  (ref_instr),
        .core_a     (core_a),
        .own_a      (ref_a),
        .core_b     (core_b),
        .own_b      (ref_b),
        .core_res   (core_res),
        .own_res    (own_res),
        .core_npc   (core_npc),
        .own_npc    (own_npc),
        .fix        (fix)
    );

    commit_chk_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (accept),
        .expire (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cv   = 1'b0;
        st_d.rreq = 1'b0;
        st_d.hold = 1'b0;
        if (accept) begin
            st_d.cv     = 1'b1;
            st_d.pc     = st_q.exp_pc;
            st_d.instr  = ref_instr;
            st_d.npc    = own_npc;
            st_d.fix    = fix;
            st_d.exp_pc = own_npc;
            if (known)           st_d.res = own_res;
            else if (st_q.recov) st_d.res = '0;
            else                 st_d.res = core_res;
            if (fix != '0) begin
                st_d.rreq = 1'b1;
                st_d.rpc  = own_npc;
                st_d.hold = 1'b1;
                st_d.err  = 1'b1;
                if (st_q.cnt != {CNT_W{1'b1}}) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.recov) begin
                st_d.left = st_q.left - 1'b1;
                if (st_q.left <= RL_W'(1)) st_d.recov = 1'b0;
            end
        end else if (expire) begin
            st_d.rreq  = 1'b1;
            st_d.rpc   = st_q.exp_pc;
            st_d.hold  = 1'b1;
            st_d.recov = 1'b1;
            st_d.left  = RL_W'(RECOV_LEN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.exp_pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = !st_q.hold;
    assign cmt_valid  = st_q.cv;
    assign cmt_pc     = st_q.pc;
    assign cmt_instr  = st_q.instr;
    assign cmt_res    = st_q.res;
    assign cmt_npc    = st_q.npc;
    assign cmt_fix    = st_q.fix;
    assign rst_req    = st_q.rreq;
    assign rst_pc     = st_q.rpc;
    assign recov      = st_q.recov;
    assign mis_cnt    = st_q.cnt;
    assign err_sticky = st_q.err;
endmodule

// File: rtl/commit_chk_sva.sv
module commit_chk_sva #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             cmt_valid,
    input logic [4:0]       cmt_fix,
    input logic [XLEN-1:0]  cmt_npc,
    input logic             rst_req,
    input logic [XLEN-1:0]  rst_pc,
    input logic             recov,
    input logic [CNT_W-1:0] mis_cnt,
    input logic             err_sticky
);
    assert_commit_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> $past(in_valid && in_ready));

    assert_fix_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_fix != '0) |-> (rst_req && rst_pc == cmt_npc));

    assert_clean_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_fix == '0) |-> !rst_req);

    assert_restart_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !in_ready);

    assert_recov_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recov) |-> rst_req);

    assert_recov_no_fix_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && $past(recov)) |-> cmt_fix == '0);

    assert_cnt_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mis_cnt >= $past(mis_cnt));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

bind commit_chk commit_chk_sva #(.XLEN(XLEN), .CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .cmt_valid  (cmt_valid),
    .cmt_fix    (cmt_fix),
    .cmt_npc    (cmt_npc),
    .rst_req    (rst_req),
    .rst_pc     (rst_pc),
    .recov      (recov),
    .mis_cnt    (mis_cnt),
    .err_sticky (err_sticky)
);

// File: tb/commit_chk_bench.sv
`timescale 1ns/1ps
module commit_chk_bench;
    localparam int          XLEN  = 32;
    localparam int          WDL   = 16;
    localparam int          RLEN  = 2;
    localparam int          CW    = 3;
    localparam logic [31:0] RPC   = 32'h0000_0100;
    localparam int          NV    = 8;

    // opcode, operand A, operand B, corruption (0 none, 1 result, 2 next PC, 3 PC, 4 instr, 5 operand)
    localparam logic [3:0]  T_OP  [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd0};
    localparam logic [31:0] T_A   [NV] = '{32'd5, 32'd3, 32'hF0F0, 32'd1, 32'hAAAA, 32'd0, 32'd77, 32'd9};
    localparam logic [31:0] T_B   [NV] = '{32'd7, 32'd10, 32'hFF00, 32'd2, 32'h5555, 32'h40, 32'd3, 32'd1};
    localparam int          T_BAD [NV] = '{0, 1, 4, 2, 5, 0, 1, 3};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [31:0]     core_pc = '0, core_instr = '0, core_a = '0, core_b = '0;
    logic [31:0]     core_res = '0, core_npc = '0;
    logic [31:0]     ref_instr = '0, ref_a = '0, ref_b = '0;
    logic            cmt_valid;
    logic [31:0]     cmt_pc, cmt_instr, cmt_res, cmt_npc, rst_pc;
    logic [4:0]      cmt_fix;
    logic            rst_req, recov, err_sticky;
    logic [CW-1:0]   mis_cnt;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] m_pc;
    int          m_cnt;
    bit          m_err;

    always #4 clk = ~clk;

    commit_chk #(
        .XLEN(XLEN), .PC_STEP(4), .WD_LIMIT(WDL), .RECOV_LEN(RLEN),
        .CNT_W(CW), .RESET_PC(RPC)
    ) u_commit_chk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .core_pc(core_pc), .core_instr(core_instr), .core_a(core_a), .core_b(core_b),
        .core_res(core_res), .core_npc(core_npc),
        .ref_instr(ref_instr), .ref_a(ref_a), .ref_b(ref_b),
        .cmt_valid(cmt_valid), .cmt_pc(cmt_pc), .cmt_instr(cmt_instr), .cmt_res(cmt_res),
        .cmt_npc(cmt_npc), .cmt_fix(cmt_fix), .rst_req(rst_req), .rst_pc(rst_pc),
        .recov(recov), .mis_cnt(mis_cnt), .err_sticky(err_sticky)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = RPC; m_cnt = 0; m_err = 1'b0;
        @(negedge clk);
        chk("R1 ready", 32'(in_ready), 32'd1);
        chk("R1 cmt_valid", 32'(cmt_valid), 32'd0);
        chk("R1 rst_req", 32'(rst_req), 32'd0);
        chk("R1 recov", 32'(recov), 32'd0);
        chk("R1 mis_cnt", 32'(mis_cnt), 32'd0);
        chk("R1 err", 32'(err_sticky), 32'd0);
    endtask

    task automatic run_instr(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             input int bad, input bit rec, input string tag);
        logic [31:0] ins, res, npc, c_res, c_npc, c_pc, c_ins, c_a, e_res;
        logic [4:0]  mask;
        bit          known;
        ins   = {op, 28'h0ABC123};
        known = (op <= 4'd5);
        npc   = (op == 4'd5) ? m_pc + b : m_pc + 32'd4;
        case (op)
            4'd0: res = a + b;
            4'd1: res = a - b;
            4'd2: res = a & b;
            4'd3: res = a | b;
            4'd4: res = a ^ b;
            4'd5: res = m_pc + b;
            default: res = 32'h5EED_0000 ^ a;
        endcase
        c_res = res; c_npc = npc; c_pc = m_pc; c_ins = ins; c_a = a;
        mask = '0;
        case (bad)
            1: begin c_res ^= 32'h1; if (known) mask = 5'b01000; end
            2: begin c_npc ^= 32'h8; mask = 5'b10000; end
            3: begin c_pc ^= 32'h4;  mask = 5'b00001; end
            4: begin c_ins ^= 32'h1; mask = 5'b00010; end
            5: begin c_a ^= 32'h10;  if (known) mask = 5'b00100; end
            default: ;
        endcase
        if (rec) mask = '0;
        e_res = known ? res : (rec ? 32'd0 : c_res);
        in_valid = 1'b1;
        core_pc = c_pc; core_instr = c_ins; core_a = c_a; core_b = b;
        core_res = c_res; core_npc = c_npc;
        ref_instr = ins; ref_a = a; ref_b = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 cmt_valid"}, 32'(cmt_valid), 32'd1);
        chk({tag, " R2 cmt_pc"}, cmt_pc, m_pc);
        chk({tag, " R2 cmt_instr"}, cmt_instr, ins);
        chk({tag, known ? " R2 cmt_res" : " R6 cmt_res"}, cmt_res, e_res);
        chk({tag, " R2 cmt_npc"}, cmt_npc, npc);
        chk({tag, rec ? " R9 cmt_fix" : " R3 cmt_fix"}, 32'(cmt_fix), 32'(mask));
        chk({tag, " R4 rst_req"}, 32'(rst_req), 32'(mask != 0));
        if (mask != 0) begin
            chk({tag, " R4 rst_pc"}, rst_pc, npc);
            chk({tag, " R5 ready low"}, 32'(in_ready), 32'd0);
            if (m_cnt < 7) m_cnt++;
            m_err = 1'b1;
        end
        chk({tag, " R10 mis_cnt"}, 32'(mis_cnt), 32'(m_cnt));
        chk({tag, " R10 err_sticky"}, 32'(err_sticky), 32'(m_err));
        m_pc = npc;
        if (mask != 0) begin
            @(negedge clk);
            chk({tag, " R5 ready back"}, 32'(in_ready), 32'd1);
            chk({tag, " R4 pulse ends"}, 32'(rst_req), 32'd0);
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        do_reset();

        // table walk: recomputation, comparisons, corrections
        for (int i = 0; i < NV; i++)
            run_instr(T_OP[i], T_A[i], T_B[i], T_BAD[i], 1'b0, $sformatf("vec%0d", i));

        // saturation of the correction counter (R10)
        for (int i = 0; i < 4; i++)
            run_instr(4'd0, 32'(i), 32'd2, 1, 1'b0, "sat R10");
        chk("R10 saturated", 32'(mis_cnt), 32'd7);

        // watchdog expiry timing (R7)
        do_reset();
        run_instr(4'd0, 32'd1, 32'd1, 0, 1'b0, "pre-wd");
        for (int i = 1; i < WDL; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R7 no early restart", 32'(rst_req), 32'd0);
        end
        @(posedge clk); @(negedge clk);
        chk("R7 restart", 32'(rst_req), 32'd1);
        chk("R7 restart pc", rst_pc, m_pc);
        chk("R7 recov", 32'(recov), 32'd1);
        chk("R7 R5 ready low", 32'(in_ready), 32'd0);
        chk("R7 no count", 32'(mis_cnt), 32'd0);

        // recovery: core claims ignored (R9)
        run_instr(4'd1, 32'd50, 32'd8, 3, 1'b1, "rec0 R9");
        chk("R9 still recov", 32'(recov), 32'd1);
        run_instr(4'd12, 32'd4, 32'd4, 2, 1'b1, "rec1 R9");
        chk("R9 recov exit", 32'(recov), 32'd0);
        chk("R9 mis_cnt kept", 32'(mis_cnt), 32'd0);
        run_instr(4'd0, 32'd2, 32'd2, 1, 1'b0, "post-rec R3");

        // accept on the expiring edge cancels the timeout (R8)
        run_instr(4'd0, 32'd6, 32'd6, 0, 1'b0, "pre-col");
        for (int i = 1; i < WDL; i++) begin
            @(posedge clk); @(negedge clk);
        end
        run_instr(4'd4, 32'hF, 32'h3, 0, 1'b0, "collide R8");
        chk("R8 no recovery", 32'(recov), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R8 no late restart", 32'(rst_req), 32'd0);

        summary();
    end
endmodule